// File: doc/BRIEF.md
# Dual-Mode Absolute Difference Tree

This block is the distortion engine of a block-matching motion search. Sixteen absolute-difference lanes, each working on two 8-bit operands, feed one balanced adder tree. The same lanes and the same tree serve two matching modes. In coarse mode the two operand vectors are the sixteen subblock sums of the current block and of one candidate block. The block returns one 12-bit subsampled distortion per candidate, one candidate per cycle. In fine mode each operand vector is one 16-pixel row, one from the current block and one from the search area. A 16-bit accumulator adds sixteen rows into the full sum of absolute differences for one candidate.

The mode input is read when a coarse candidate is presented and when a fine accumulation begins. While an accumulation is in progress, every valid cycle is taken as the next row, whatever the mode input says. A cycle with no valid input stalls the accumulation. A start pulse clears the accumulator and makes its cycle the first row. The tree has a single register stage at its output, so every result appears one clock after the input that produced it.

Top module: `sad_dual_tree`

## Requirements
- R1: After reset, coarseValid and fineDone are both 0.
- R2: With no accumulation in progress, a cycle with inValid=1 and modeFine=0 gives coarseValid=1 on the next cycle. coarseDist is then the sum over lanes i=0..15 of |cur_i - ref_i|, where lane i sits at bits [8i+7:8i] of curVec and refVec. Back-to-back inputs give back-to-back results.
- R3: A cycle with no coarse input leaves coarseValid at 0 on the next cycle, and coarseDist keeps its last value.
- R4: A cycle with inValid=1, rowStart=1 and modeFine=1 clears the accumulator and counts as row 1 of a new accumulation.
- R5: After 16 valid rows, fineSad equals the sum of all 16 row distortions, and fineDone is 1 for exactly the one cycle that follows the 16th row. fineDone is 0 after each of the first 15 rows.
- R6: During an accumulation, a cycle with inValid=0 adds nothing and does not count as a row.
- R7: During an accumulation, modeFine is ignored: a valid row with modeFine=0 is accumulated and does not raise coarseValid.
- R8: A valid cycle with rowStart=1 during an accumulation restarts it, discarding the earlier rows.
- R9: With no accumulation in progress, a valid cycle with modeFine=1 and rowStart=0 is dropped. It raises neither output flag and does not change the next accumulation's result.
- R10: Full-scale operands (every lane 0 against 255) give coarseDist=4080 and fineSad=65280 with no wrap.
- R11: The cycle right after the 16th row may carry a coarse candidate, and it gives a coarse result on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operand vectors valid this cycle |
| modeFine | input | 1 | 0 = coarse subblock-sum match, 1 = fine pixel-row match |
| rowStart | input | 1 | Begins (or restarts) a fine accumulation |
| curVec | input | 128 | Sixteen 8-bit current-block operands, lane i at [8i+7:8i] |
| refVec | input | 128 | Sixteen 8-bit candidate operands, lane i at [8i+7:8i] |
| coarseValid | output | 1 | coarseDist holds a new result |
| coarseDist | output | 12 | Coarse distortion of the previous cycle's candidate |
| fineDone | output | 1 | fineSad holds a completed 16-row sum |
| fineSad | output | 16 | Fine accumulated distortion |

## Verification
The bench goes after the edges of an accumulation. A row counter that is off by one would pulse fineDone after row 15 or row 17, or leave it high for two cycles. A design that counts idle cycles as rows would finish early when the bench inserts stalls. Other faults show up in the mode and start handling. A design that rereads the mode input in the middle of an accumulation would emit a stray coarse result and lose a row. One that accepts a fine row without a start pulse, or ignores a restart, would return a sum that includes stale rows. Full-scale operands expose truncated adder or accumulator widths as wrapped values. A coarse candidate right after the last row catches a controller that needs an extra idle cycle to return to coarse mode.

// File: rtl/sad_tree_pkg.sv
package sad_tree_pkg;
  // Strobes from the controller to the datapath, valid in the input cycle.
  typedef struct packed {
    logic loadCoarse; // capture tree sum as a coarse result
    logic accRow;     // add tree sum into the accumulator
    logic accFirst;   // accumulator starts from zero for this row
    logic lastRow;    // this row completes the block
  } sadCtrl_t;
endpackage

// File: rtl/sad_tree_ctrl.sv
module sad_tree_ctrl
  import sad_tree_pkg::*;
#(
  parameter int ROWS = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     modeFine,
  input  logic     rowStart,
  output sadCtrl_t ctl
);
  localparam int CNTW = (ROWS > 2) ? $clog2(ROWS) : 1;
  localparam logic [CNTW-1:0] LASTCNT = CNTW'(ROWS - 1);

  logic            busy;
  logic [CNTW-1:0] rowCnt;
  logic            startFine;
  logic            rowFine;

  // Mode is looked at only when no accumulation is running.
  always_comb begin
    startFine      = inValid && rowStart && (busy || modeFine);
    rowFine        = inValid && (busy || startFine);
    ctl.loadCoarse = inValid && !busy && !modeFine;
    ctl.accRow     = rowFine;
    ctl.accFirst   = startFine;
    ctl.lastRow    = rowFine && !startFine && (rowCnt == LASTCNT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      rowCnt <= '0;
    end else if (startFine) begin
      busy   <= 1'b1;
      rowCnt <= CNTW'(1);
    end else if (rowFine) begin
      if (ctl.lastRow) begin
        busy   <= 1'b0;
        rowCnt <= '0;
      end else begin
        rowCnt <= rowCnt + CNTW'(1);
      end
    end
  end

  // R5: a running accumulation has always absorbed at least one row
  p_busy_cnt_r5: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (rowCnt != '0));

  // R11: the last row returns the controller to idle
  p_last_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    ctl.lastRow |=> !busy);

  // R7: no coarse capture while rows are being accumulated
  p_no_coarse_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !ctl.loadCoarse);
endmodule

// File: rtl/sad_tree_dp.sv
module sad_tree_dp
  import sad_tree_pkg::*;
#(
  parameter int LANES = 16,
  parameter int OPW   = 8,
  parameter int SUMW  = 12,
  parameter int ACCW  = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  sadCtrl_t               ctl,
  input  logic [LANES*OPW-1:0]   curVec,
  input  logic [LANES*OPW-1:0]   refVec,
  output logic                   coarseVld,
  output logic [SUMW-1:0]        coarseReg,
  output logic                   doneReg,
  output logic [ACCW-1:0]        accReg
);
  // Heap-ordered tree: leaves at LANES..2*LANES-1, root at 1.
  logic [SUMW-1:0] node [1:2*LANES-1];
  logic [SUMW-1:0] treeSum;

  for (genvar lane = 0; lane < LANES; lane++) begin : g_ad
    logic [OPW-1:0] opA;
    logic [OPW-1:0] opB;
    logic [OPW-1:0] absDiff;
    assign opA     = curVec[lane*OPW +: OPW];
    assign opB     = refVec[lane*OPW +: OPW];
    assign absDiff = (opA >= opB) ? (opA - opB) : (opB - opA);
    assign node[LANES+lane] = SUMW'(absDiff);
  end

  for (genvar n = 1; n < LANES; n++) begin : g_add
    assign node[n] = node[2*n] + node[2*n+1];
  end

  assign treeSum = node[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coarseVld <= 1'b0;
      coarseReg <= '0;
      doneReg   <= 1'b0;
      accReg    <= '0;
    end else begin
      coarseVld <= ctl.loadCoarse;
      doneReg   <= ctl.accRow && ctl.lastRow;
      if (ctl.loadCoarse) coarseReg <= treeSum;
      if (ctl.accRow)
        accReg <= (ctl.accFirst ? '0 : accReg) + ACCW'(treeSum);
    end
  end

  // R10: a continuing accumulation never wraps below its previous value
  p_acc_no_wrap_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.accRow && !ctl.accFirst) |=> (accReg >= $past(accReg)));

  // R3: coarse result is held when nothing new is loaded
  p_coarse_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadCoarse |=> $stable(coarseReg));
endmodule

// File: rtl/sad_dual_tree.sv
module sad_dual_tree
  import sad_tree_pkg::*;
#(
  parameter int LANES = 16,
  parameter int OPW   = 8,
  parameter int ROWS  = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic                 modeFine,
  input  logic                 rowStart,
  input  logic [LANES*OPW-1:0] curVec,
  input  logic [LANES*OPW-1:0] refVec,
  output logic                 coarseValid,
  output logic [OPW+$clog2(LANES)-1:0] coarseDist,
  output logic                 fineDone,
  output logic [OPW+$clog2(LANES)+$clog2(ROWS)-1:0] fineSad
);
  localparam int SUMW = OPW + $clog2(LANES);
  localparam int ACCW = SUMW + $clog2(ROWS);

  sadCtrl_t ctl;

  sad_tree_ctrl #(.ROWS(ROWS)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .modeFine(modeFine),
    .rowStart(rowStart), .ctl(ctl)
  );

  sad_tree_dp #(.LANES(LANES), .OPW(OPW), .SUMW(SUMW), .ACCW(ACCW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .curVec(curVec), .refVec(refVec),
    .coarseVld(coarseValid), .coarseReg(coarseDist),
    .doneReg(fineDone), .accReg(fineSad)
  );

  // R2: every coarse result comes from a valid coarse-mode input one cycle earlier
  p_coarse_lat_r2: assert property (@(posedge clk) disable iff (!rstN)
    coarseValid |-> $past(inValid && !modeFine));

  // R5: completion is a single-cycle pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    fineDone |=> !fineDone);

  // R9: a completion needs a valid row in the cycle before
  p_done_src_r9: assert property (@(posedge clk) disable iff (!rstN)
    fineDone |-> $past(inValid));
endmodule

// File: tb/sad_dual_tree_test.sv
module sad_dual_tree_test;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 6;
  localparam logic [127:0] CUR_T [NT] = '{
    128'h0,
    {16{8'hFF}},
    128'h00112233_44556677_8899AABB_CCDDEEFF,
    {16{8'h80}},
    128'h0102_0304_0506_0708_090A_0B0C_0D0E_0F10,
    128'hDEADBEEF_CAFEF00D_12345678_9ABCDEF0
  };
  localparam logic [127:0] REF_T [NT] = '{
    128'h0,
    128'h0,
    128'hFFEEDDCC_BBAA9988_77665544_33221100,
    {16{8'h7F}},
    128'h1010_1010_1010_1010_1010_1010_1010_1010,
    128'h0BADC0DE_FEEDFACE_87654321_0FEDCBA9
  };

  logic clk = 0, rstN = 0, inValid = 0, modeFine = 0, rowStart = 0;
  logic [127:0] curVec = '0, refVec = '0;
  logic coarseValid, fineDone;
  logic [11:0] coarseDist;
  logic [15:0] fineSad;
  int nRun = 0, nFail = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sad_dual_tree uut (.*);

  function automatic int vsad(logic [127:0] a, logic [127:0] b);
    int s = 0;
    for (int i = 0; i < 16; i++) begin
      int x = a[8*i +: 8];
      int y = b[8*i +: 8];
      s += (x > y) ? x - y : y - x;
    end
    return s;
  endfunction

  function automatic logic [127:0] rowPat(int seed, int r);
    logic [127:0] v;
    for (int i = 0; i < 16; i++) v[8*i +: 8] = 8'(seed*37 + r*11 + i*23 + r*i*5);
    return v;
  endfunction

  task automatic check(string req, int act, int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one cycle of input at the falling edge, sample just after the rising edge.
  task automatic drive(logic v, logic m, logic s, logic [127:0] c, logic [127:0] r);
    @(negedge clk);
    inValid = v; modeFine = m; rowStart = s; curVec = c; refVec = r;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    drive(0, 0, 0, '0, '0);
  endtask

  // Feed 16 rows (seed a/b); optional stall after row stallAt; checks fineDone per row.
  task automatic fineBlock(int sa, int sb, int stallAt, logic midMode, output int expSum);
    expSum = 0;
    for (int r = 0; r < 16; r++) begin
      logic [127:0] c = rowPat(sa, r);
      logic [127:0] f = rowPat(sb, r);
      expSum += vsad(c, f);
      drive(1, (r == 0) ? 1'b1 : midMode, (r == 0), c, f);
      if (r < 15) check("R5 early done", fineDone, 0);
      check("R7 no coarse in fine", coarseValid, 0);
      if (r == stallAt) begin
        idle(); idle();
        check("R6 stall no done", fineDone, 0);
      end
    end
  endtask

  initial begin
    while (cycles < 20000) begin @(posedge clk); cycles++; end
    nRun++; nFail++;
    $display("FAIL watchdog actual=%0d expected<20000", cycles);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int e;
    int e2;
    repeat (3) @(posedge clk);
    #1;
    check("R1 coarseValid reset", coarseValid, 0);
    check("R1 fineDone reset", fineDone, 0);
    @(negedge clk); rstN = 1;

    // R2: table-driven coarse, back to back
    for (int k = 0; k < NT; k++) begin
      drive(1, 0, 0, CUR_T[k], REF_T[k]);
      check("R2 coarseValid", coarseValid, 1);
      check("R2 coarseDist", coarseDist, vsad(CUR_T[k], REF_T[k]));
    end
    // R3: hold
    e = vsad(CUR_T[NT-1], REF_T[NT-1]);
    idle();
    check("R3 coarseValid low", coarseValid, 0);
    check("R3 coarseDist held", coarseDist, e);

    // R10: full scale coarse
    drive(1, 0, 0, {16{8'hFF}}, '0);
    check("R10 coarse full", coarseDist, 4080);

    // R4/R5: plain fine block
    fineBlock(3, 9, -1, 1'b1, e);
    check("R5 done", fineDone, 1);
    check("R5 sum", fineSad, e);
    // R11: coarse right after last row
    drive(1, 0, 0, CUR_T[2], REF_T[2]);
    check("R5 done one cycle", fineDone, 0);
    check("R11 coarse after fine", coarseValid, 1);
    check("R11 coarse value", coarseDist, vsad(CUR_T[2], REF_T[2]));

    // R6 + R7: stalls and mode flipped mid-block
    fineBlock(7, 1, 5, 1'b0, e);
    check("R6 R7 done", fineDone, 1);
    check("R6 R7 sum", fineSad, e);
    idle();

    // R9: orphan fine row dropped, then clean block
    drive(1, 1, 0, {16{8'hFF}}, '0);
    check("R9 no coarse", coarseValid, 0);
    check("R9 no done", fineDone, 0);
    fineBlock(11, 4, -1, 1'b1, e);
    check("R9 sum unaffected", fineSad, e);

    // R8: restart after 5 rows
    for (int r = 0; r < 5; r++) drive(1, 1, (r == 0), {16{8'hFF}}, '0);
    fineBlock(2, 13, -1, 1'b1, e2);
    check("R8 restart done", fineDone, 1);
    check("R8 restart sum", fineSad, e2);
    idle();

    // R10: full scale fine
    for (int r = 0; r < 16; r++) drive(1, 1, (r == 0), '0, {16{8'hFF}});
    check("R10 fine done", fineDone, 1);
    check("R10 fine full", fineSad, 65280);
    idle();
    check("R5 done drops", fineDone, 0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule